// File: doc/BRIEF.md
# Cycle-Skipping Switch Gate Controller

This block makes the gate-drive decision for a power switch that regulates by skipping whole switching cycles instead of varying the pulse width. The external oscillator sends a one-clock pulse at the start of each switching cycle, and this block samples the enable request only on that pulse. If the request is high and no protection fault is present, the switch conducts for that cycle. If the request is low, the cycle is skipped and the gate stays low until the next cycle-start pulse.

A pulse that has started ends at the first of three events: the current-limit comparator trips, the maximum duty-cycle window closes, or a protection fault appears. For a programmable number of system clocks after turn-on, the block ignores the current-limit comparator so that edge spikes cannot cut the pulse short. There are two protection faults, low supply and over-temperature. Each one latches and clears only when its own recovery flag asserts, so each fault has hysteresis between two thresholds.

The gate output is registered. It follows each decision one system clock later.

Top module: `cycskip_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_o` is 0 at once, whatever the inputs do. Reset clears both fault latches, so the first cycle-start pulse after reset can turn the switch on.
- R2: If `cyc_start_i`, `en_req_i` and `dmax_i` are all 1 on a clock edge and no fault is present, `gate_o` is 1 after that edge. If `en_req_i` is 0 on that edge, `gate_o` is 0 after it.
- R3: The enable request is sampled only on the cycle-start edge. A low `en_req_i` while the switch conducts does not end the pulse. A high `en_req_i` with no cycle-start pulse never turns the switch on.
- R4: If `ilim_i` is 1 on an edge where the switch conducts and blanking has expired, `gate_o` is 0 after that edge. It stays 0 until the next cycle-start pulse.
- R5: `ilim_i` is ignored on the turn-on edge and on the next `BLANK_CLKS` edges. If `ilim_i` is held at 1 from turn-on, `gate_o` stays 1 for exactly `BLANK_CLKS`+1 clocks (5 with the default of 4).
- R6: If `dmax_i` is 0 on an edge, `gate_o` is 0 after that edge.
- R7: `sup_low_i` = 1 sets the supply-fault latch and forces `gate_o` to 0 after that edge. The latch clears only on an edge with `sup_ok_i` = 1 and `sup_low_i` = 0. If both are 1, setting wins.
- R8: `temp_hot_i` = 1 sets the thermal-fault latch and forces `gate_o` to 0 after that edge. The latch clears only on an edge with `temp_cool_i` = 1 and `temp_hot_i` = 0. If both are 1, setting wins.
- R9: A fault that is present on a cycle-start edge blocks that sample. The blocked sample is not remembered: if the fault clears in the middle of a cycle, the switch stays off until the next cycle-start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | One-clock pulse that marks the start of a switching cycle |
| dmax_i | input | 1 | Maximum duty window; 1 while conduction is allowed |
| en_req_i | input | 1 | Enable request from the feedback comparator |
| ilim_i | input | 1 | Current-limit comparator output |
| sup_low_i | input | 1 | Supply has fallen below its lower threshold |
| sup_ok_i | input | 1 | Supply has recovered above its upper threshold |
| temp_hot_i | input | 1 | Die temperature is above the shutdown threshold |
| temp_cool_i | input | 1 | Die has cooled below the restart threshold |
| gate_o | output | 1 | Registered gate-on command for the power switch |

## Verification
Every piece of internal state in this block shows up at `gate_o` within one clock of the first cycle-start pulse that depends on it.

- A fault latch that clears too early lets the switch turn on at a start edge that should have been blocked.
- A fault latch that stays set blocks the start edge after recovery.
- A blanking counter that is off by one shifts the falling edge of a pulse with current limit held high by one clock from the `BLANK_CLKS`+1 position.
- A phase state that is wrong shows up as a pulse that starts between cycle-start pulses, or as a pulse that does not end when the duty window closes.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int FLT_SUPPLY = 0;
    localparam int FLT_THERM  = 1;
    localparam int NUM_FLT    = 2;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_COND = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   gate;
    } fsm_state_t;

endpackage

// File: rtl/gcs_fault_latch.sv
module gcs_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flt_o
);
    logic flt_d, flt_q;

    // set has priority over clear
    always_comb begin
        flt_d = flt_q;
        if (set_i)      flt_d = 1'b1;
        else if (clr_i) flt_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= 1'b0;
        else        flt_q <= flt_d;
    end

    assign flt_o = flt_q;
endmodule

// File: rtl/gcs_blank_timer.sv
module gcs_blank_timer #(
    parameter int BLANK_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CNT_W = (BLANK_CLKS < 1) ? 1 : $clog2(BLANK_CLKS + 1);

    generate
        if (BLANK_CLKS == 0) begin : g_none
            assign busy_o = 1'b0;
        end else begin : g_cnt
            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (load_i)            cnt_d = CNT_W'(BLANK_CLKS);
                else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign busy_o = (cnt_q != '0);
        end
    endgenerate
endmodule

// File: rtl/gcs_gate_fsm.sv
module gcs_gate_fsm
    import gcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start_i,
    input  logic dmax_i,
    input  logic en_req_i,
    input  logic ilim_i,
    input  logic fault_i,
    input  logic blank_busy_i,
    output logic turn_on_o,
    output logic gate_o
);
    fsm_state_t st_d, st_q;

    // priority: fault, then cycle start, then pulse-ending events
    always_comb begin
        st_d      = st_q;
        turn_on_o = 1'b0;
        if (fault_i) begin
            st_d.phase = PH_DONE;
            st_d.gate  = 1'b0;
        end else if (cyc_start_i) begin
            if (en_req_i && dmax_i) begin
                st_d.phase = PH_COND;
                st_d.gate  = 1'b1;
                turn_on_o  = 1'b1;
            end else begin
                st_d.phase = PH_DONE;
                st_d.gate  = 1'b0;
            end
        end else if (st_q.phase == PH_COND) begin
            if (!dmax_i || (ilim_i && !blank_busy_i)) begin
                st_d.phase = PH_DONE;
                st_d.gate  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_WAIT, gate: 1'b0};
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;
endmodule

// File: rtl/cycskip_gate_ctrl.sv
module cycskip_gate_ctrl
    import gcs_pkg::*;
#(
    parameter int BLANK_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start_i,
    input  logic dmax_i,
    input  logic en_req_i,
    input  logic ilim_i,
    input  logic sup_low_i,
    input  logic sup_ok_i,
    input  logic temp_hot_i,
    input  logic temp_cool_i,
    output logic gate_o
);
    logic [NUM_FLT-1:0] flt_set, flt_clr, flt_q;
    logic fault_any, turn_on, blank_busy;

    assign flt_set[FLT_SUPPLY] = sup_low_i;
    assign flt_clr[FLT_SUPPLY] = sup_ok_i;
    assign flt_set[FLT_THERM]  = temp_hot_i;
    assign flt_clr[FLT_THERM]  = temp_cool_i;

    generate
        for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
            gcs_fault_latch u_latch (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (flt_set[i]),
                .clr_i (flt_clr[i]),
                .flt_o (flt_q[i])
            );
        end
    endgenerate

    // raw set inputs act in the same cycle; latched state holds until recovery
    assign fault_any = (|flt_q) | (|flt_set);

    gcs_blank_timer #(.BLANK_CLKS(BLANK_CLKS)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (turn_on),
        .busy_o (blank_busy)
    );

    gcs_gate_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start_i  (cyc_start_i),
        .dmax_i       (dmax_i),
        .en_req_i     (en_req_i),
        .ilim_i       (ilim_i),
        .fault_i      (fault_any),
        .blank_busy_i (blank_busy),
        .turn_on_o    (turn_on),
        .gate_o       (gate_o)
    );
endmodule

// File: rtl/cycskip_gate_ctrl_chk.sv
module cycskip_gate_ctrl_chk #(
    parameter int BLANK_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_start_i,
    input logic dmax_i,
    input logic en_req_i,
    input logic ilim_i,
    input logic sup_low_i,
    input logic temp_hot_i,
    input logic gate_o
);
    // clocks since the last cycle-start edge while conducting
    logic [15:0] on_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                on_cnt_q <= '0;
        else if (cyc_start_i)      on_cnt_q <= '0;
        else if (gate_o && on_cnt_q != 16'hFFFF) on_cnt_q <= on_cnt_q + 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (gate_o == 1'b0)
                else $error("gate high during reset");
        end
    end

    assert_turn_on_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(cyc_start_i && en_req_i && dmax_i));

    assert_no_midcycle_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_o && !cyc_start_i) |=> !gate_o);

    assert_ilim_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && ilim_i && !cyc_start_i && (32'(on_cnt_q) >= BLANK_CLKS)) |=> !gate_o);

    assert_dmax_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dmax_i |=> !gate_o);

    assert_fault_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_low_i || temp_hot_i) |=> !gate_o);
endmodule

bind cycskip_gate_ctrl cycskip_gate_ctrl_chk #(.BLANK_CLKS(BLANK_CLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .dmax_i      (dmax_i),
    .en_req_i    (en_req_i),
    .ilim_i      (ilim_i),
    .sup_low_i   (sup_low_i),
    .temp_hot_i  (temp_hot_i),
    .gate_o      (gate_o)
);

// File: tb/cycskip_gate_ctrl_tb.sv
module cycskip_gate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start_i = 0, dmax_i = 0, en_req_i = 0, ilim_i = 0;
    logic sup_low_i = 0, sup_ok_i = 0, temp_hot_i = 0, temp_cool_i = 0;
    logic gate_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cycskip_gate_ctrl #(.BLANK_CLKS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i), .dmax_i(dmax_i),
        .en_req_i(en_req_i), .ilim_i(ilim_i), .sup_low_i(sup_low_i),
        .sup_ok_i(sup_ok_i), .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i),
        .gate_o(gate_o)
    );

    // {tag, start dmax en ilim slow sok thot tcool, expected gate after edge}
    localparam logic [12:0] VEC [NVEC] = '{
        {4'd2, 8'b1110_0000, 1'b1},  // R2 turn on
        {4'd3, 8'b0100_0000, 1'b1},  // R3 enable drop ignored
        {4'd5, 8'b0101_0000, 1'b1},  // R5 blanked
        {4'd5, 8'b0101_0000, 1'b1},  // R5
        {4'd5, 8'b0101_0000, 1'b1},  // R5
        {4'd4, 8'b0101_0000, 1'b0},  // R4 limit acts
        {4'd4, 8'b0110_0000, 1'b0},  // R4 stays off
        {4'd6, 8'b0000_0000, 1'b0},  // R6
        {4'd2, 8'b1100_0000, 1'b0},  // R2 skipped cycle
        {4'd3, 8'b0110_0000, 1'b0},  // R3 no mid-cycle on
        {4'd6, 8'b0000_0000, 1'b0},  // R6
        {4'd2, 8'b1110_0000, 1'b1},  // R2
        {4'd6, 8'b0100_0000, 1'b1},  // R6 window open
        {4'd6, 8'b0000_0000, 1'b0},  // R6 window closes
        {4'd2, 8'b1110_0000, 1'b1},  // R2
        {4'd8, 8'b0110_0010, 1'b0},  // R8 hot mid-pulse
        {4'd8, 8'b0110_0000, 1'b0},  // R8
        {4'd8, 8'b1110_0000, 1'b0},  // R8 latched blocks start
        {4'd8, 8'b0000_0001, 1'b0},  // R8 cooled
        {4'd8, 8'b1110_0000, 1'b1},  // R8 restart
        {4'd7, 8'b0110_1000, 1'b0},  // R7 low supply
        {4'd7, 8'b0110_0000, 1'b0},  // R7
        {4'd7, 8'b1110_0000, 1'b0},  // R7 latched
        {4'd7, 8'b0000_0100, 1'b0},  // R7 recovered
        {4'd7, 8'b1110_0000, 1'b1},  // R7 restart
        {4'd5, 8'b0101_0000, 1'b1},  // R5 limit in blanking
        {4'd6, 8'b0000_0000, 1'b0},  // R6
        {4'd5, 8'b1111_0000, 1'b1},  // R5 limit at turn-on edge
        {4'd6, 8'b0000_0000, 1'b0},  // R6
        {4'd8, 8'b0000_0011, 1'b0},  // R8 set wins
        {4'd8, 8'b1110_0000, 1'b0},  // R8
        {4'd8, 8'b0000_0001, 1'b0},  // R8
        {4'd8, 8'b1110_0000, 1'b1},  // R8
        {4'd6, 8'b0000_0000, 1'b0},  // R6
        {4'd9, 8'b1110_1000, 1'b0},  // R9 fault on start edge
        {4'd9, 8'b0100_0100, 1'b0},  // R9
        {4'd9, 8'b1110_0000, 1'b1},  // R9
        {4'd6, 8'b0000_0000, 1'b0},  // R6
        {4'd9, 8'b1110_0010, 1'b0},  // R9 blocked sample
        {4'd9, 8'b0110_0001, 1'b0},  // R9 cleared mid-cycle
        {4'd9, 8'b0110_0000, 1'b0},  // R9 not remembered
        {4'd9, 8'b1110_0000, 1'b1},  // R9
        {4'd6, 8'b0000_0000, 1'b0}   // R6
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gate_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [7:0] b);
        {cyc_start_i, dmax_i, en_req_i, ilim_i, sup_low_i, sup_ok_i, temp_hot_i, temp_cool_i} = b;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", gate_o, 1'b0);                 // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", gate_o, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][8:1]);
            @(negedge clk);
            check($sformatf("R%0d", VEC[i][12:9]), gate_o, VEC[i][0]);
        end

        // R1: asynchronous reset forces gate low mid-pulse
        drive(8'b1110_0000);
        @(negedge clk);
        check("R2", gate_o, 1'b1);
        drive(8'b0110_0000);
        #2 rst_n = 1'b0;
        #1 check("R1", gate_o, 1'b0);
        @(negedge clk);
        // R1: inputs ignored during reset, thermal latch set beforehand is cleared
        drive(8'b1110_0010);
        @(negedge clk);
        check("R1", gate_o, 1'b0);
        drive(8'b0000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        drive(8'b1110_0000);
        @(negedge clk);
        check("R1", gate_o, 1'b1);                 // R1 latches cleared by reset
        // R5: limit held from turn-on, gate high for 5 clocks
        drive(8'b0101_0000);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R5", gate_o, 1'b1);
        end
        @(negedge clk);
        check("R4", gate_o, 1'b0);
        drive(8'b0000_0000);
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule